// File: doc/BRIEF.md
# Quadrature Encoder Decoder

This block turns the two phase signals of an incremental rotary or linear encoder, plus an optional index pulse, into a signed position count and a direction bit. Each input pin first passes through its own polarity control. The two phases can then trade places. Each conditioned signal is sampled into the clock domain and passed through a per-input glitch filter of programmable length. A single-cycle decoder then compares the filtered phases with their previous values. It counts every phase edge, or only the edges of phase A. It notes reversals and flags the case where both phases move at once, which is illegal.

Three sticky event flags record index, direction reversal and quadrature error. An interrupt mask is kept beside them and is changed by separate set and clear strobes. The interrupt line is the OR of the flags that are unmasked. Reading the status with a one-cycle strobe returns the flags and clears them. All configuration arrives on plain input pins. No streaming data crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `qdec_top`

## Requirements
- R1: After reset the position is 0, the direction is 0 (forward), all status bits are 0, the mask is 0 and the interrupt is low.
- R2: With {A,B} written as two bits, the sequence 00→10→11→01→00 is forward. Each step adds 1 to the position and sets direction (status bit 8) to 0. The opposite sequence subtracts 1 per step and sets direction to 1. Results appear within four clocks of a pin change when filtering is off.
- R3: When edge-on-A mode is set, only phase A transitions change the position. Phase B transitions leave it unchanged.
- R4: The phase A inversion control and the phase B inversion control each invert their own pin before decoding. Inverting a single phase reverses the sign of the count for the same pin motion.
- R5: The swap control exchanges the two conditioned phases, which reverses the sign of counting.
- R6: When both filtered phases change in the same cycle, the position is unchanged and the quadrature error flag (status bit 2) is set.
- R7: A rising edge of the conditioned index forces the position to 0 and sets the index flag (status bit 0). A falling index edge has no effect. The index inversion control selects which pin level counts as rising.
- R8: When index-from-B is set, the phase B pin (through the index inversion) is the index source and the dedicated index pin is ignored.
- R9: With filtering enabled and limit M, a change on an input must persist for M+1 consecutive clocks before it takes effect. A pulse of M clocks is discarded.
- R10: A counted or uncounted single-phase step whose direction differs from the stored direction sets the direction-change flag (status bit 1).
- R11: A 1 on a bit of the enable strobe sets that mask bit, and a 1 on a bit of the disable strobe clears it. Disable wins when both strobes carry the same bit. The interrupt output is high when any flag is set together with its mask bit.
- R12: Flags are sticky. A one-cycle read strobe clears them on the next clock, but an event in the same cycle stays set. The direction bit is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pha_i | input | 1 | Phase A pin |
| phb_i | input | 1 | Phase B pin |
| idx_i | input | 1 | Dedicated index pin |
| cfg_inv_a | input | 1 | Invert phase A pin |
| cfg_inv_b | input | 1 | Invert phase B pin |
| cfg_inv_idx | input | 1 | Invert index source |
| cfg_swap | input | 1 | Exchange phases A and B |
| cfg_idx_on_b | input | 1 | Take index from phase B pin |
| cfg_edge_a | input | 1 | Count phase A transitions only |
| cfg_filt_en | input | 1 | Enable input glitch filter |
| cfg_filt_max | input | FILT_W | Filter limit M (hold M+1 clocks) |
| irq_en_set | input | 3 | Mask set strobe, one bit per flag |
| irq_dis_set | input | 3 | Mask clear strobe, one bit per flag |
| status_rd | input | 1 | Status read strobe, clears flags |
| pos_o | output | POS_W | Signed position count |
| dir_o | output | 1 | Current direction, 1 = reverse |
| status_o | output | 9 | Bits 0..2 flags (index, dir change, error), bit 8 direction |
| irq_mask_o | output | 3 | Interrupt mask |
| irq_o | output | 1 | Interrupt request |

## Verification
A table of phase steps walks forward through the Gray cycle, reverses, passes through zero into negative counts and turns forward again. This separates the handling of rising and falling edges on each phase and checks sign-extended wrap-free arithmetic. Directed steps then repeat single-pin moves under each of inversion, swap and edge-on-A. Because each of these controls predicts the opposite sign, or no step at all, for the same pin motion, a mix-up between them is exposed. Simultaneous phase changes separate the error path from counting. Index pulses on the dedicated pin versus phase B show which source is live. Filter pulses of exactly M and M+1 clocks pin down the filter boundary.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  localparam int NFLG     = 3;
  localparam int FLG_IDX  = 0;
  localparam int FLG_DCHG = 1;
  localparam int FLG_QERR = 2;
  localparam int STAT_W   = 9;
  localparam int STAT_DIR = 8;
  localparam int NCH      = 3;
  localparam int CH_A     = 0;
  localparam int CH_B     = 1;
  localparam int CH_I     = 2;
endpackage

// File: rtl/qdec_filter.sv
module qdec_filter #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] lim,
  input  logic          d,
  output logic          q
);
  localparam logic [CW-1:0] CONE = 1;
  logic [CW-1:0] run_cnt;

  // a differing sample must be seen lim+1 times in a row before q follows
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q       <= 1'b0;
      run_cnt <= '0;
    end else if (!en) begin
      q       <= d;
      run_cnt <= '0;
    end else if (d == q) begin
      run_cnt <= '0;
    end else if (run_cnt == lim) begin
      q       <= d;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + CONE;
    end
  end
endmodule

// File: rtl/qdec_count.sv
module qdec_count #(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fa,
  input  logic             fb,
  input  logic             fi,
  input  logic             edge_a,
  output logic [POS_W-1:0] pos,
  output logic             dir,
  output logic             ev_idx,
  output logic             ev_dchg,
  output logic             ev_qerr
);
  localparam logic [POS_W-1:0] PONE = 1;
  logic prev_a, prev_b, prev_i;
  logic chg_a, chg_b, one_step, fwd, cnt_en;

  always_comb begin
    chg_a    = fa ^ prev_a;
    chg_b    = fb ^ prev_b;
    one_step = chg_a ^ chg_b;
    // A moving away from B, or B moving onto A, is forward
    fwd      = chg_a ? (fa != fb) : (fb == fa);
    cnt_en   = one_step & (~edge_a | chg_a);
    ev_qerr  = chg_a & chg_b;
    ev_idx   = fi & ~prev_i;
    ev_dchg  = one_step & ((~fwd) != dir);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_a <= 1'b0;
      prev_b <= 1'b0;
      prev_i <= 1'b0;
      pos    <= '0;
      dir    <= 1'b0;
    end else begin
      prev_a <= fa;
      prev_b <= fb;
      prev_i <= fi;
      if (ev_idx)      pos <= '0;
      else if (cnt_en) pos <= fwd ? pos + PONE : pos - PONE;
      if (one_step)    dir <= ~fwd;
    end
  end
endmodule

// File: rtl/qdec_flags.sv
module qdec_flags
  import qdec_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NFLG-1:0] ev,
  input  logic [NFLG-1:0] en_set,
  input  logic [NFLG-1:0] dis_set,
  input  logic            rd,
  output logic [NFLG-1:0] flags,
  output logic [NFLG-1:0] mask,
  output logic            irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      mask  <= '0;
    end else begin
      flags <= (flags & ~{NFLG{rd}}) | ev;
      mask  <= (mask | en_set) & ~dis_set;
    end
  end

  assign irq = |(flags & mask);
endmodule

// File: rtl/qdec_top.sv
module qdec_top
  import qdec_pkg::*;
#(
  parameter int POS_W  = 16,
  parameter int FILT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pha_i,
  input  logic              phb_i,
  input  logic              idx_i,
  input  logic              cfg_inv_a,
  input  logic              cfg_inv_b,
  input  logic              cfg_inv_idx,
  input  logic              cfg_swap,
  input  logic              cfg_idx_on_b,
  input  logic              cfg_edge_a,
  input  logic              cfg_filt_en,
  input  logic [FILT_W-1:0] cfg_filt_max,
  input  logic [2:0]        irq_en_set,
  input  logic [2:0]        irq_dis_set,
  input  logic              status_rd,
  output logic [POS_W-1:0]  pos_o,
  output logic              dir_o,
  output logic [8:0]        status_o,
  output logic [2:0]        irq_mask_o,
  output logic              irq_o
);
  logic a_pol, b_pol;
  logic [NCH-1:0] cond, samp, filt;
  logic [NFLG-1:0] ev_vec, flags;
  logic ev_idx, ev_dchg, ev_qerr;

  always_comb begin
    a_pol      = pha_i ^ cfg_inv_a;
    b_pol      = phb_i ^ cfg_inv_b;
    cond[CH_A] = cfg_swap ? b_pol : a_pol;
    cond[CH_B] = cfg_swap ? a_pol : b_pol;
    cond[CH_I] = (cfg_idx_on_b ? phb_i : idx_i) ^ cfg_inv_idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) samp <= '0;
    else        samp <= cond;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_filt
    qdec_filter #(.CW(FILT_W)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (cfg_filt_en),
      .lim   (cfg_filt_max),
      .d     (samp[g]),
      .q     (filt[g])
    );
  end

  qdec_count #(.POS_W(POS_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .fa      (filt[CH_A]),
    .fb      (filt[CH_B]),
    .fi      (filt[CH_I]),
    .edge_a  (cfg_edge_a),
    .pos     (pos_o),
    .dir     (dir_o),
    .ev_idx  (ev_idx),
    .ev_dchg (ev_dchg),
    .ev_qerr (ev_qerr)
  );

  always_comb begin
    ev_vec           = '0;
    ev_vec[FLG_IDX]  = ev_idx;
    ev_vec[FLG_DCHG] = ev_dchg;
    ev_vec[FLG_QERR] = ev_qerr;
  end

  qdec_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (ev_vec),
    .en_set  (irq_en_set),
    .dis_set (irq_dis_set),
    .rd      (status_rd),
    .flags   (flags),
    .mask    (irq_mask_o),
    .irq     (irq_o)
  );

  always_comb begin
    status_o               = '0;
    status_o[NFLG-1:0]     = flags;
    status_o[STAT_DIR]     = dir_o;
  end
endmodule

// File: rtl/qdec_checker.sv
module qdec_checker #(
  parameter int POS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [POS_W-1:0] pos_o,
  input logic [8:0]       status_o,
  input logic             status_rd,
  input logic [2:0]       irq_en_set,
  input logic [2:0]       irq_dis_set,
  input logic [2:0]       irq_mask_o,
  input logic             ev_idx,
  input logic             ev_qerr
);
  localparam logic [POS_W-1:0] PONE = 1;

  p_pos_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pos_o) |-> (pos_o == '0 || (pos_o - $past(pos_o)) == PONE ||
                         ($past(pos_o) - pos_o) == PONE));

  p_qerr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_qerr && !ev_idx) |=> $stable(pos_o));

  p_qerr_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_qerr |=> status_o[2]);

  p_idx_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_idx |=> (pos_o == '0 && status_o[0]));

  p_mask_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|(irq_en_set & ~irq_dis_set)) |=>
      ((irq_mask_o & $past(irq_en_set & ~irq_dis_set)) == $past(irq_en_set & ~irq_dis_set)));

  p_mask_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_dis_set) |=> ((irq_mask_o & $past(irq_dis_set)) == 3'b000));

  p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[2:0] != 3'b000 && !status_rd) |=>
      ((status_o[2:0] & $past(status_o[2:0])) == $past(status_o[2:0])));
endmodule

bind qdec_top qdec_checker #(.POS_W(POS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pos_o       (pos_o),
  .status_o    (status_o),
  .status_rd   (status_rd),
  .irq_en_set  (irq_en_set),
  .irq_dis_set (irq_dis_set),
  .irq_mask_o  (irq_mask_o),
  .ev_idx      (ev_idx),
  .ev_qerr     (ev_qerr)
);

// File: tb/qdec_top_tb_top.sv
module qdec_top_tb_top;
  localparam int POS_W  = 16;
  localparam int FILT_W = 6;
  localparam int NVEC   = 15;
  // {a, b, dir, unused, pos[7:0]}
  localparam logic [11:0] VEC [NVEC] = '{
    {3'b100, 1'b0, 8'd1},   {3'b110, 1'b0, 8'd2},   {3'b010, 1'b0, 8'd3},
    {3'b000, 1'b0, 8'd4},   {3'b100, 1'b0, 8'd5},   {3'b001, 1'b0, 8'd4},
    {3'b011, 1'b0, 8'd3},   {3'b111, 1'b0, 8'd2},   {3'b101, 1'b0, 8'd1},
    {3'b001, 1'b0, 8'd0},   {3'b011, 1'b0, 8'hFF},  {3'b111, 1'b0, 8'hFE},
    {3'b101, 1'b0, 8'hFD},  {3'b001, 1'b0, 8'hFC},  {3'b100, 1'b0, 8'hFD}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pha = 1'b0, phb = 1'b0, idx = 1'b0;
  logic inv_a = 1'b0, inv_b = 1'b0, inv_idx = 1'b0, swp = 1'b0;
  logic idx_on_b = 1'b0, edge_a = 1'b0, filt_en = 1'b0;
  logic [FILT_W-1:0] filt_max = '0;
  logic [2:0] en_set = '0, dis_set = '0;
  logic rd = 1'b0;
  logic [POS_W-1:0] pos;
  logic dir, irq;
  logic [8:0] status;
  logic [2:0] mask;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  qdec_top #(.POS_W(POS_W), .FILT_W(FILT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .pha_i(pha), .phb_i(phb), .idx_i(idx),
    .cfg_inv_a(inv_a), .cfg_inv_b(inv_b), .cfg_inv_idx(inv_idx), .cfg_swap(swp),
    .cfg_idx_on_b(idx_on_b), .cfg_edge_a(edge_a), .cfg_filt_en(filt_en),
    .cfg_filt_max(filt_max), .irq_en_set(en_set), .irq_dis_set(dis_set),
    .status_rd(rd), .pos_o(pos), .dir_o(dir), .status_o(status),
    .irq_mask_o(mask), .irq_o(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int spos();
    return int'($signed(pos));
  endfunction

  task automatic restart();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic step(input logic a, input logic b);
    pha = a;
    phb = b;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_seen(input int len, output bit seen);
    seen = 1'b0;
    pha = 1'b1;
    repeat (len) @(negedge clk);
    pha = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (pos != '0) seen = 1'b1;
    end
  endtask

  initial begin
    bit seen;
    restart();
    // R1 reset state
    check("R1 pos", spos(), 0);
    check("R1 status", int'(status), 0);
    check("R1 mask/irq", int'({mask, irq}), 0);

    // R2 table walk
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][11], VEC[i][10]);
      check($sformatf("R2 row%0d pos", i), spos(), int'($signed(VEC[i][7:0])));
      check($sformatf("R2 row%0d dir", i), int'(status[8]), int'(VEC[i][9]));
    end

    // R3 edge-on-A only
    pha = 0; phb = 0; edge_a = 1; restart();
    step(1, 0); check("R3 A rise", spos(), 1);
    step(1, 1); check("R3 B ignored", spos(), 1);
    step(0, 1); check("R3 A fall", spos(), 2);
    step(0, 0); check("R3 B ignored 2", spos(), 2);
    edge_a = 0;

    // R4 inversion of A: pins 10->11 counts reverse
    pha = 1; phb = 0; inv_a = 1; restart();
    step(1, 1); check("R4 inv A", spos(), -1);
    inv_a = 0;
    // R4 inversion of B: pins 01->11 counts forward
    pha = 0; phb = 1; inv_b = 1; restart();
    step(1, 1); check("R4 inv B", spos(), 1);
    inv_b = 0;

    // R5 swap: pins 00->10 counts reverse
    pha = 0; phb = 0; swp = 1; restart();
    step(1, 0); check("R5 swap", spos(), -1);
    swp = 0;

    // R6 quadrature error
    pha = 0; phb = 0; restart();
    step(1, 0);
    step(0, 1); check("R6 pos held", spos(), 1);
    check("R6 qerr flag", int'(status[2]), 1);

    // R7 index on dedicated pin
    restart();
    step(1, 0); step(1, 1);
    idx = 1; repeat (4) @(negedge clk);
    check("R7 index zero", spos(), 0);
    check("R7 index flag", int'(status[0]), 1);
    idx = 0; repeat (4) @(negedge clk);
    step(0, 1); check("R7 falling ignored", spos(), 1);
    // R7 inverted index: pin falling is the active edge
    pha = 0; phb = 0; idx = 1; inv_idx = 1; restart();
    step(1, 0);
    idx = 0; repeat (4) @(negedge clk);
    check("R7 inv index", spos(), 0);
    inv_idx = 0;

    // R8 index from phase B
    idx = 0; edge_a = 1; idx_on_b = 1; restart();
    step(1, 0);
    idx = 1; repeat (4) @(negedge clk);
    check("R8 pin ignored", spos(), 1);
    idx = 0;
    step(1, 1);
    check("R8 B index zero", spos(), 0);
    check("R8 B index flag", int'(status[0]), 1);
    edge_a = 0; idx_on_b = 0;

    // R9 filter boundary, M = 5
    pha = 0; phb = 0; filt_en = 1; filt_max = 6'd5; restart();
    pulse_seen(5, seen); check("R9 short pulse", int'(seen), 0);
    pulse_seen(6, seen); check("R9 long pulse", int'(seen), 1);
    filt_en = 0; filt_max = '0;

    // R10 direction change
    restart();
    step(1, 0); check("R10 no change", int'(status[1]), 0);
    step(0, 0); check("R10 reversal", int'(status[1]), 1);

    // R11 mask
    en_set = 3'b010; @(negedge clk); en_set = 3'b000;
    check("R11 mask set", int'(mask), 2);
    check("R11 irq high", int'(irq), 1);
    en_set = 3'b100; dis_set = 3'b110; @(negedge clk);
    en_set = 3'b000; dis_set = 3'b000;
    check("R11 disable wins", int'(mask), 0);
    check("R11 irq low", int'(irq), 0);

    // R12 read clears flags, keeps direction
    rd = 1; @(negedge clk); rd = 0;
    check("R12 flags cleared", int'(status[2:0]), 0);
    check("R12 dir kept", int'(status[8]), 1);
    @(negedge clk);
    check("R12 stays clear", int'(status[2:0]), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule